// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block is the interrupt unit of a small 8-bit controller core. It takes event pulses from six sources: two external pins, a comparator output, a PWM period event and two timer overflows. Each event sets its own request flag, and the flag stays set until the request is serviced or software clears it. Two 8-bit control registers hold these flags together with one enable bit per source and a global master enable. The core writes the registers through a simple write port and reads them back on two read ports.

Arbitration only takes place on cycles where the core raises its sampling-phase strobe. On such a cycle, if the master enable is set and the core's stack is not full, the block picks the highest-priority source whose flag and enable are both set. On that clock edge it clears the master enable and the chosen flag. In the next cycle it raises a one-cycle request carrying the source's 3-bit code and its vector address. No further request can be made until the core pulses its return-with-interrupt input or software sets the master enable again.

Top module: `irq_arbiter`

## Requirements
- R1: The source codes, in order of priority from highest, are 1 = external 0, 2 = external 1, 3 = comparator, 4 = PWM period, 5 = timer 0, 6 = timer 1. `irq_addr` equals the code times 4 (04h to 18h). `irq_vec` and `irq_addr` read 0 when `irq_req` is low.
- R2: An acknowledge happens only at a clock edge where `phase_t2` is high. `irq_req` is high for exactly the one cycle that follows that edge.
- R3: A source takes part in arbitration only if its flag, its enable bit and the master enable are all set. Among the sources that do, the one with the lowest code wins.
- R4: At the acknowledge edge, the master enable and the winner's flag are cleared. All other flags keep their values.
- R5: While `stack_full` is high, no acknowledge happens and pending flags are kept.
- R6: A `reti` pulse sets the master enable. Once an acknowledge has cleared the master enable, no new acknowledge follows until `reti` or a software write sets it again.
- R7: Control register 0 (`wr_sel`=0) has this layout: bit0 master enable, bit1 external-0 enable, bit2 external-1 enable, bit3 comparator enable, bit4 external-0 flag, bit5 external-1 flag, bit6 comparator flag. Bit7 reads 0. A write replaces all of the fields.
- R8: Control register 1 (`wr_sel`=1) has this layout: bit0 timer-0 enable, bit1 timer-1 enable, bit2 PWM enable, bit4 timer-0 flag, bit5 timer-1 flag, bit6 PWM flag. Bits 3 and 7 always read 0, and writes to them have no effect.
- R9: A flag is set by its event pulse whether or not the source is enabled. If an event arrives in the same cycle as a software clear or an acknowledge of that flag, the flag ends up set.
- R10: After reset, both registers read 0 and `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_t2 | input | 1 | Sampling-phase strobe; arbitration is allowed only when high |
| src_evt | input | 6 | Event pulses; bit k belongs to source code k+1 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Selects the register written: 0 = register 0, 1 = register 1 |
| wr_data | input | 8 | Write data |
| reti | input | 1 | Return-with-interrupt pulse |
| stack_full | input | 1 | Call stack is full; blocks acknowledges |
| irq_req | output | 1 | One-cycle interrupt request to the core |
| irq_vec | output | 3 | Code of the serviced source |
| irq_addr | output | 8 | Vector address of the serviced source |
| ctl0_rd | output | 8 | Contents of control register 0 |
| ctl1_rd | output | 8 | Contents of control register 1 |

## Verification
All the state of this block is visible on the two read ports. A wrong flag, enable or master bit therefore shows up as a register mismatch in the cycle right after the edge that produced it. A fault in arbitration or in the acknowledge condition shows up on `irq_req` and `irq_vec` one cycle after the sampling edge concerned. The bench compares every output against a behavioural model on every cycle, so each fault is reported at the first edge where it takes effect.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int VEC_STEP = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phase_t2,
  input  logic [5:0] src_evt,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       reti,
  input  logic       stack_full,
  output logic       irq_req,
  output logic [2:0] irq_vec,
  output logic [7:0] irq_addr,
  output logic [7:0] ctl0_rd,
  output logic [7:0] ctl1_rd
);
  localparam int NSRC = 6;

  logic            master;
  logic [NSRC-1:0] en, fl;
  logic [NSRC-1:0] live, ack_mask, fl_wmask, fl_wval, en_wval, fl_n;
  logic [2:0]      win_idx;
  logic            hit, ack, wr0, wr1;

  assign wr0  = wr_en & ~wr_sel;
  assign wr1  = wr_en &  wr_sel;
  assign live = fl & en;

  always_comb begin
    win_idx = '0;
    hit     = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (live[i]) begin
        win_idx = 3'(i);
        hit     = 1'b1;
      end
  end

  assign ack      = phase_t2 & master & ~stack_full & hit;
  assign ack_mask = ack ? (NSRC'(1) << win_idx) : '0;

  assign fl_wmask = {wr1, wr1, wr1, wr0, wr0, wr0};
  assign fl_wval  = {wr_data[5], wr_data[4], wr_data[6], wr_data[6], wr_data[5], wr_data[4]};
  assign en_wval  = {wr_data[1], wr_data[0], wr_data[2], wr_data[3], wr_data[2], wr_data[1]};
  assign fl_n     = (fl_wmask & fl_wval) | (~fl_wmask & fl & ~ack_mask) | src_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master  <= 1'b0;
      en      <= '0;
      fl      <= '0;
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else begin
      fl      <= fl_n;
      en      <= (fl_wmask & en_wval) | (~fl_wmask & en);
      irq_req <= ack;
      irq_vec <= ack ? win_idx + 3'd1 : 3'd0;
      if (wr0)       master <= wr_data[0];
      else if (ack)  master <= 1'b0;
      else if (reti) master <= 1'b1;
    end
  end

  assign irq_addr = 8'(irq_vec) * 8'(VEC_STEP);
  assign ctl0_rd  = {1'b0, fl[2], fl[1], fl[0], en[2], en[1], en[0], master};
  assign ctl1_rd  = {1'b0, fl[3], fl[5], fl[4], 1'b0, en[3], en[5], en[4]};
endmodule

module irq_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       phase_t2,
  input logic       wr_en,
  input logic       wr_sel,
  input logic       reti,
  input logic       stack_full,
  input logic       irq_req,
  input logic [2:0] irq_vec,
  input logic [7:0] ctl0_rd
);
  p_req_on_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(phase_t2));
  p_req_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !$past(wr_en && !wr_sel) |=> !irq_req);
  p_vec_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec >= 3'd1 && irq_vec <= 3'd6));
  p_master_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !$past(wr_en && !wr_sel) |-> !ctl0_rd[0]);
  p_stack_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !$past(stack_full));
  p_reti_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reti) && !$past(wr_en && !wr_sel) && !irq_req |-> ctl0_rd[0]);
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phase_t2(phase_t2), .wr_en(wr_en), .wr_sel(wr_sel),
  .reti(reti), .stack_full(stack_full), .irq_req(irq_req), .irq_vec(irq_vec),
  .ctl0_rd(ctl0_rd)
);

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;
  logic       clk = 0, rst_n = 0, phase_t2 = 0, wr_en = 0, wr_sel = 0, reti = 0, stack_full = 0;
  logic [5:0] src_evt = 0;
  logic [7:0] wr_data = 0;
  logic       irq_req;
  logic [2:0] irq_vec;
  logic [7:0] irq_addr, ctl0_rd, ctl1_rd;

  irq_arbiter uut (.*);

  always #10 clk = ~clk;

  int vectors = 0, fails = 0, cyc = 0;
  bit m_master, m_req;
  bit m_en[6], m_fl[6];
  int m_vec;

  // Behavioural model of the requirements (R1..R10)
  always @(posedge clk) begin
    if (!rst_n) begin
      m_master = 0; m_req = 0; m_vec = 0;
      foreach (m_en[k]) begin m_en[k] = 0; m_fl[k] = 0; end
    end else begin
      int w; bit ack; bit wrA, wrB;
      w = -1;
      for (int k = 0; k < 6; k++) if (w < 0 && m_fl[k] && m_en[k]) w = k;
      ack = phase_t2 && m_master && !stack_full && w >= 0;
      wrA = wr_en && !wr_sel; wrB = wr_en && wr_sel;
      if (ack) m_fl[w] = 0;
      if (wrA) begin
        m_en[0] = wr_data[1]; m_en[1] = wr_data[2]; m_en[2] = wr_data[3];
        m_fl[0] = wr_data[4]; m_fl[1] = wr_data[5]; m_fl[2] = wr_data[6];
      end
      if (wrB) begin
        m_en[4] = wr_data[0]; m_en[5] = wr_data[1]; m_en[3] = wr_data[2];
        m_fl[4] = wr_data[4]; m_fl[5] = wr_data[5]; m_fl[3] = wr_data[6];
      end
      for (int k = 0; k < 6; k++) if (src_evt[k]) m_fl[k] = 1;
      if (wrA) m_master = wr_data[0];
      else if (ack) m_master = 0;
      else if (reti) m_master = 1;
      m_req = ack;
      m_vec = ack ? w + 1 : 0;
    end
  end

  function automatic logic [7:0] exp0();
    return {1'b0, m_fl[2], m_fl[1], m_fl[0], m_en[2], m_en[1], m_en[0], m_master};
  endfunction
  function automatic logic [7:0] exp1();
    return {1'b0, m_fl[3], m_fl[5], m_fl[4], 1'b0, m_en[3], m_en[5], m_en[4]};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    chk("R2 R3 R5 R6 R10 irq_req", int'(irq_req), int'(m_req));
    chk("R1 R3 irq_vec", int'(irq_vec), m_vec);
    chk("R1 irq_addr", int'(irq_addr), m_vec * 4);
    chk("R4 R7 R9 R10 ctl0", int'(ctl0_rd), int'(exp0()));
    chk("R4 R8 R9 ctl1", int'(ctl1_rd), int'(exp1()));
  end

  // sampling phase: one edge in four
  always @(negedge clk) begin #2; phase_t2 <= (cyc % 4 == 3); end

  task automatic step(input logic [5:0] e = 0, input bit w = 0, input bit s = 0,
                      input logic [7:0] d = 0, input bit r = 0);
    @(negedge clk); #2;
    src_evt = e; wr_en = w; wr_sel = s; wr_data = d; reti = r;
    @(negedge clk); #2;
    src_evt = 0; wr_en = 0; reti = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    idle(4); // R10 reset state compared each cycle
    @(negedge clk); #2; rst_n = 1;
    // R9: events latch while disabled
    step(6'h3F); idle(8);
    // R7 R8: enable everything; R3 priority drains in order via R6 reti
    step(0, 1, 1, 8'hFF);
    step(0, 1, 0, 8'h7F);
    for (int k = 0; k < 7; k++) begin idle(6); step(0, 0, 0, 0, 1); end
    // R5: stack full holds pending flags
    stack_full = 1; step(6'h21); idle(12); stack_full = 0; idle(8);
    step(0, 0, 0, 0, 1); idle(8);
    // R9: event beats software clear of same flag
    step(6'h02, 1, 0, 8'h00); idle(4);
    step(6'h10, 1, 1, 8'h00); idle(4);
    // R3: disabled source loses to enabled lower priority one
    step(0, 1, 0, 8'h01); step(6'h11, 1, 1, 8'h01); idle(8);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk); #2;
      src_evt    = ($urandom % 6 == 0) ? 6'($urandom) : 6'h0;
      wr_en      = ($urandom % 10 == 0);
      wr_sel     = 1'($urandom);
      wr_data    = 8'($urandom);
      reti       = ($urandom % 8 == 0);
      stack_full = ($urandom % 5 == 0);
    end
    @(negedge clk); #2;
    src_evt = 0; wr_en = 0; reti = 0; stack_full = 0;
    idle(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule